// File: doc/BRIEF.md
# Serial-Clocked Wiper Step Engine

This block moves digital potentiometer wipers one tap at a time, clocked by the serial bus itself. The bus front end finishes byte framing and acknowledges the step-mode instruction. It then pulses `mode_en` and presents the chosen pot number. From that point the engine watches the filtered clock and data levels. Each completed clock high phase moves the selected wiper one tap. The direction comes from the data level: high steps up, low steps down. The engine keeps stepping until the front end reports a STOP.

The engine holds the volatile wiper registers, four by default, each six bits wide with 64 taps. A wiper that is already at the top or bottom tap stays there. Direction is captured on the clock rising edge. The step is committed only when the clock falls with the data line unchanged. A data edge during the high phase is a START or STOP, so it cancels the pending step. For this reason the final clock pulse before a STOP never moves a wiper. The step request is also brought out as a one-cycle pulse so that other logic can follow the wiper activity.

Top module: `wiper_step_engine`

## Requirements
- R1: After reset every wiper holds WIPER_RST (default 32) and `step_vld` is low.
- R2: While the mode is active, a clock high phase with `sda` = 1 that ends with `scl` falling raises the selected wiper by one and reports `step_up` = 1.
- R3: While the mode is active, a clock high phase with `sda` = 0 that ends with `scl` falling lowers the selected wiper by one and reports `step_up` = 0.
- R4: An up step on a wiper at 63 leaves it at 63.
- R5: A down step on a wiper at 0 leaves it at 0.
- R6: Only the wiper whose index was on `pot_sel` when `mode_en` was high changes. Later changes of `pot_sel` have no effect, and the other wipers keep their values.
- R7: Clock pulses before `mode_en` change no wiper and raise no `step_vld`.
- R8: A `stop_det` pulse ends the mode, and later clock pulses change no wiper.
- R9: If `sda` changes while `scl` is high (a START or STOP), that high phase produces no step.
- R10: `step_vld` is a one-cycle pulse in the cycle after the first clock edge that samples `scl` low following a valid high phase. The wiper takes its new value one cycle after that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl | input | 1 | Filtered serial clock level, synchronous to clk |
| sda | input | 1 | Filtered serial data level, synchronous to clk |
| mode_en | input | 1 | One-cycle pulse from the front end: step mode acknowledged |
| stop_det | input | 1 | One-cycle pulse from the front end: STOP seen |
| pot_sel | input | POT_W (2) | Pot index, captured with mode_en |
| step_vld | output | 1 | One-cycle step request |
| step_up | output | 1 | Direction of the request, 1 = up |
| step_pot | output | POT_W (2) | Pot index of the request |
| wiper_flat | output | NPOT*WBITS (24) | All wiper values, pot i at bits [i*WBITS +: WBITS] |

## Verification
A step shows on `step_vld` in the cycle after the first clock edge that samples `scl` low. The wiper value follows one cycle later. The bench lowers `scl` on a falling clk edge, samples the request at the next falling edge, and samples the wipers at the one after that. Inactive, START and STOP cases are checked only after the same window has passed, so a late step would still be seen. The checker ties each request to the wiper change on the next cycle and ties each wiper change back to a request.

// File: rtl/wstep_pkg.sv
// Shared types and helpers for the serial-clocked wiper step engine.
// Assumes wiper widths of at most 31 bits.
package wstep_pkg;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } step_dir_e;

    // Saturating one-tap move of a wiper value within [0, top].
    function automatic int unsigned sat_move(int unsigned cur, step_dir_e dir, int unsigned top);
        if (dir == DIR_UP) begin
            return (cur >= top) ? top : cur + 1;
        end
        return (cur == 0) ? 0 : cur - 1;
    endfunction

endpackage

// File: rtl/wstep_edge.sv
// Serial clock edge finder. Registers the filtered SCL level and reports
// rising, falling and held-high phases. Assumes scl is already synchronous
// to clk and filtered. The register resets high to match an idle bus.
module wstep_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    output logic scl_rise,
    output logic scl_fall,
    output logic scl_held
);

    logic scl_q;

    // Delay SCL by one cycle for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
        end else begin
            scl_q <= scl;
        end
    end

    // Classify the current SCL phase.
    always_comb begin
        scl_rise = scl & ~scl_q;
        scl_fall = ~scl & scl_q;
        scl_held = scl & scl_q;
    end

endmodule

// File: rtl/wstep_ctrl.sv
// Step mode controller. Arms on mode_en and captures the pot index. Records
// the SDA level at each SCL rise, cancels the pending step if SDA moves while
// SCL stays high, and issues a one-cycle step request on the SCL fall.
// stop_det has priority over mode_en. Assumes mode_en arrives while SCL is low.
module wstep_ctrl #(
    parameter int POT_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mode_en,
    input  logic                    stop_det,
    input  logic [POT_W-1:0]        pot_sel,
    input  logic                    sda,
    input  logic                    scl_rise,
    input  logic                    scl_fall,
    input  logic                    scl_held,
    output logic                    active,
    output logic                    step_vld,
    output wstep_pkg::step_dir_e    step_dir,
    output logic [POT_W-1:0]        step_pot
);
    import wstep_pkg::*;

    logic       active_q;
    logic       pend_q;
    step_dir_e  dir_q;
    logic [POT_W-1:0] pot_q;
    logic       vld_q;

    // Mode state, pending step and request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            pend_q   <= 1'b0;
            dir_q    <= DIR_DOWN;
            pot_q    <= '0;
            vld_q    <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (stop_det) begin
                active_q <= 1'b0;
                pend_q   <= 1'b0;
            end else if (mode_en) begin
                active_q <= 1'b1;
                pot_q    <= pot_sel;
                pend_q   <= 1'b0;
            end else if (active_q) begin
                if (scl_rise) begin
                    pend_q <= 1'b1;
                    dir_q  <= step_dir_e'(sda);
                end else if (pend_q && scl_held && (sda != logic'(dir_q))) begin
                    pend_q <= 1'b0;
                end else if (pend_q && scl_fall) begin
                    pend_q <= 1'b0;
                    vld_q  <= 1'b1;
                end
            end
        end
    end

    // Drive the request interface from state.
    always_comb begin
        active   = active_q;
        step_vld = vld_q;
        step_dir = dir_q;
        step_pot = pot_q;
    end

endmodule

// File: rtl/wstep_bank.sv
// Volatile wiper register bank. On each step request it moves the indexed
// wiper one tap, saturating at both ends. Assumes at most one request a cycle.
module wstep_bank #(
    parameter int NPOT      = 4,
    parameter int WBITS     = 6,
    parameter int WIPER_RST = 32,
    parameter int POT_W     = (NPOT > 1) ? $clog2(NPOT) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step_vld,
    input  wstep_pkg::step_dir_e    step_dir,
    input  logic [POT_W-1:0]        step_pot,
    output logic [NPOT*WBITS-1:0]   wiper_flat
);
    import wstep_pkg::*;

    localparam int unsigned TOP = (1 << WBITS) - 1;

    for (genvar gi = 0; gi < NPOT; gi++) begin : g_pot
        logic [WBITS-1:0] w_q;

        // Hold one wiper; step it when the request names this pot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                w_q <= WBITS'(WIPER_RST);
            end else if (step_vld && (step_pot == POT_W'(gi))) begin
                w_q <= WBITS'(sat_move(32'(w_q), step_dir, TOP));
            end
        end

        assign wiper_flat[gi*WBITS +: WBITS] = w_q;
    end

endmodule

// File: rtl/wiper_step_engine.sv
// Serial-clocked wiper step engine, top level. Joins the SCL edge finder, the
// step controller and the wiper bank. Assumes filtered, clk-synchronous scl
// and sda, and one-cycle mode_en and stop_det pulses from the bus front end.
module wiper_step_engine #(
    parameter int NPOT      = 4,
    parameter int WBITS     = 6,
    parameter int WIPER_RST = 32,
    parameter int POT_W     = (NPOT > 1) ? $clog2(NPOT) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl,
    input  logic                    sda,
    input  logic                    mode_en,
    input  logic                    stop_det,
    input  logic [POT_W-1:0]        pot_sel,
    output logic                    step_vld,
    output logic                    step_up,
    output logic [POT_W-1:0]        step_pot,
    output logic [NPOT*WBITS-1:0]   wiper_flat
);
    import wstep_pkg::*;

    logic      scl_rise;
    logic      scl_fall;
    logic      scl_held;
    logic      mode_act;
    step_dir_e step_dir;

    wstep_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl      (scl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .scl_held (scl_held)
    );

    wstep_ctrl #(.POT_W(POT_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_en  (mode_en),
        .stop_det (stop_det),
        .pot_sel  (pot_sel),
        .sda      (sda),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .scl_held (scl_held),
        .active   (mode_act),
        .step_vld (step_vld),
        .step_dir (step_dir),
        .step_pot (step_pot)
    );

    wstep_bank #(
        .NPOT      (NPOT),
        .WBITS     (WBITS),
        .WIPER_RST (WIPER_RST),
        .POT_W     (POT_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_vld   (step_vld),
        .step_dir   (step_dir),
        .step_pot   (step_pot),
        .wiper_flat (wiper_flat)
    );

    // Export the direction as a plain level.
    assign step_up = (step_dir == DIR_UP);

endmodule

// File: rtl/wstep_chk.sv
// Property checker for the wiper step engine, bound to the top module.
module wstep_chk #(
    parameter int NPOT  = 4,
    parameter int WBITS = 6,
    parameter int POT_W = (NPOT > 1) ? $clog2(NPOT) : 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl,
    input logic                  step_vld,
    input logic                  step_up,
    input logic [POT_W-1:0]      step_pot,
    input logic                  mode_act,
    input logic [NPOT*WBITS-1:0] wiper_flat
);
    localparam logic [WBITS-1:0] TOPV = {WBITS{1'b1}};

    logic [POT_W-1:0] last_pot;
    logic [WBITS-1:0] sel_w;
    logic [WBITS-1:0] last_w;

    // Remember which pot the previous request named.
    always_ff @(posedge clk) begin
        if (!rst_n) last_pot <= '0;
        else        last_pot <= step_pot;
    end

    assign sel_w  = wiper_flat[step_pot*WBITS +: WBITS];
    assign last_w = wiper_flat[last_pot*WBITS +: WBITS];

    // R2
    step_up_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_vld && step_up && (sel_w != TOPV) |=> last_w == WBITS'($past(sel_w) + 1'b1));

    // R3
    step_down_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_vld && !step_up && (sel_w != '0) |=> last_w == WBITS'($past(sel_w) - 1'b1));

    // R4
    top_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_vld && step_up && (sel_w == TOPV) |=> $stable(wiper_flat));

    // R5
    bottom_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_vld && !step_up && (sel_w == '0) |=> $stable(wiper_flat));

    // R6
    no_request_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_vld |=> $stable(wiper_flat));

    // R8
    idle_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_act |=> !step_vld);

    // R10
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_vld |=> !step_vld);

    // R10
    after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_vld |-> !$past(scl));

endmodule

bind wiper_step_engine wstep_chk #(.NPOT(NPOT), .WBITS(WBITS), .POT_W(POT_W)) u_chk (.*);

// File: tb/wiper_step_engine_tb.sv
module wiper_step_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int WB = 6;
    localparam int TOPV = 63;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic mode_en = 1'b0;
    logic stop_det = 1'b0;
    logic [1:0] pot_sel = '0;
    logic step_vld;
    logic step_up;
    logic [1:0] step_pot;
    logic [NP*WB-1:0] wiper_flat;

    int checks = 0;
    int errors = 0;
    int mw[NP];
    bit m_act = 1'b0;
    int m_pot = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wiper_step_engine u_dut (
        .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda),
        .mode_en(mode_en), .stop_det(stop_det), .pot_sel(pot_sel),
        .step_vld(step_vld), .step_up(step_up), .step_pot(step_pot),
        .wiper_flat(wiper_flat)
    );

    function automatic int dut_w(int i);
        return int'(wiper_flat[i*WB +: WB]);
    endfunction

    function automatic int model_step(int cur, bit up);
        if (up) return (cur >= TOPV) ? TOPV : cur + 1;
        return (cur == 0) ? 0 : cur - 1;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_all(string req);
        for (int i = 0; i < NP; i++) chk(req, dut_w(i), mw[i]);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_low();
        if (scl) begin
            scl = 1'b0;
            tick(3);
        end
    endtask

    // One full clock pulse on the bus with data level d.
    task automatic pulse(bit d, string idle_req);
        bit exp_step;
        string req;
        scl_low();
        sda = d;
        tick(1);
        scl = 1'b1;
        tick(3);
        scl = 1'b0;
        exp_step = m_act;
        tick(1);
        chk(exp_step ? "R10" : idle_req, int'(step_vld), int'(exp_step));
        if (exp_step) chk(d ? "R2" : "R3", int'(step_up), int'(d));
        tick(1);
        if (exp_step) begin
            if (d) req = (mw[m_pot] == TOPV) ? "R4" : "R2";
            else   req = (mw[m_pot] == 0) ? "R5" : "R3";
            mw[m_pot] = model_step(mw[m_pot], d);
            for (int i = 0; i < NP; i++) chk((i == m_pot) ? req : "R6", dut_w(i), mw[i]);
        end else begin
            chk_all(idle_req);
        end
    endtask

    task automatic enter(int p);
        scl_low();
        pot_sel = 2'(p);
        mode_en = 1'b1;
        tick(1);
        mode_en = 1'b0;
        pot_sel = 2'(p + 1);
        m_act = 1'b1;
        m_pot = p;
    endtask

    // STOP after a rising SCL with data low: no step may result.
    task automatic do_stop();
        scl_low();
        sda = 1'b0;
        tick(1);
        scl = 1'b1;
        tick(2);
        sda = 1'b1;
        tick(1);
        stop_det = 1'b1;
        tick(1);
        stop_det = 1'b0;
        m_act = 1'b0;
        tick(3);
        chk_all("R9");
    endtask

    // START-like data fall in a high phase while active: no step.
    task automatic do_glitch();
        scl_low();
        sda = 1'b1;
        tick(1);
        scl = 1'b1;
        tick(2);
        sda = 1'b0;
        tick(2);
        scl = 1'b0;
        tick(3);
        chk_all("R9");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < NP; i++) mw[i] = 32;
        tick(4);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        chk_all("R1");
        chk("R1", int'(step_vld), 0);
        // R7 pulses before the mode is entered
        for (int i = 0; i < 3; i++) pulse(i[0], "R7");
        // R2, R3, R6 on pot 2
        enter(2);
        for (int i = 0; i < 5; i++) pulse(1'b1, "R2");
        for (int i = 0; i < 3; i++) pulse(1'b0, "R3");
        do_stop();
        // R4 saturate at top on pot 1
        enter(1);
        for (int i = 0; i < 40; i++) pulse(1'b1, "R4");
        do_stop();
        // R5 saturate at bottom on pot 0
        enter(0);
        for (int i = 0; i < 40; i++) pulse(1'b0, "R5");
        do_glitch();
        do_stop();
        // R8 pulses after the mode ended
        for (int i = 0; i < 3; i++) pulse(1'b1, "R8");
        // Random mix of steps, stops, glitches and re-entries
        for (int i = 0; i < 400; i++) begin
            int r;
            r = int'($urandom % 20);
            if (r == 0) begin
                if (m_act) do_stop();
                enter(int'($urandom % NP));
            end else if (r == 1) begin
                if (m_act) do_glitch();
            end else begin
                pulse(1'($urandom), "R8");
            end
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule